// File: doc/BRIEF.md
# Relative Branch Sequencer

This block runs the bus side of conditional relative branches for an 8-bit processor that has a 16-bit program counter and only an 8-bit adder. Every clock cycle is one memory read. The block fetches a branch opcode and then a signed 8-bit displacement. In the third cycle it tests one chosen status flag. A branch that is not taken continues in sequence. A taken branch adds the displacement to the low byte of the program counter. When the target lands in a different 256-byte page, the block spends one more cycle on a throw-away read while it steps the high byte up or down.

The surrounding core treats every fetched opcode as a branch whose condition comes from the select input. The opcode-fetch strobe marks the cycles where the bus address is an instruction start. The completion pulse reports how many cycles the branch that just finished took (2, 3 or 4), so that timing can be checked directly at the ports.

Top module: `rel_branch_seq`

## Requirements
- R1: While reset is held, the address bus shows the reset program counter, the opcode-fetch strobe is high and the completion pulse is low.
- R2: A branch at address P reads its opcode at P in one cycle (strobe high) and its displacement at P+1 in the next cycle (strobe low).
- R3: cond_sel[2:1] selects the tested flag (0 = negative, 1 = overflow, 2 = zero, 3 = carry) and cond_sel[0] is the wanted value. The branch is taken when the selected flag equals the wanted value, sampled in the branch's third cycle.
- R4: When not taken, the third cycle reads P+2 as the next opcode (strobe high), and the completion pulse is high in that same cycle with count 2.
- R5: The target is P+2 plus the sign-extended displacement, modulo 2^16.
- R6: When taken within the same page, the third cycle reads P+2 with the strobe low (the byte is discarded). The fourth cycle fetches the opcode at the target, with the completion pulse and count 3.
- R7: When taken across a page, the fourth cycle is a dummy read at {high byte of P+2, low byte of target} with the strobe low. The fifth cycle fetches the opcode at the target, with the completion pulse and count 4. The worked case is a branch at 0x0100 with displacement 0xB0, which reads 0x01B2 and then 0x00B2.
- R8: The completion pulse lasts one cycle and comes only at the first opcode fetch after a finished branch. It is never asserted at the first fetch after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | ADDR_W | Read address driven every cycle |
| mem_rdata | input | DATA_W | Byte returned for mem_addr, sampled at the end of the cycle |
| cond_sel | input | 3 | Flag index in [2:1], wanted value in [0] |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| op_fetch | output | 1 | Current bus cycle is an opcode fetch |
| br_done | output | 1 | Completion pulse for the previous branch |
| br_cycles | output | 3 | Cycle count of that branch (2, 3 or 4) while br_done is high |

## Verification
Each result is due in a known cycle counted from the branch's opcode cycle. The displacement read lands one cycle later. The not-taken next fetch and its count-2 pulse land two cycles later, and they depend combinationally on flags sampled in that cycle. The same-page target fetch lands three cycles later. The dummy read lands three cycles later and the corrected fetch four cycles later. The bench expands each branch into a queue of expected bus cycles, using its own 16-bit target arithmetic. It pops one entry per clock and compares it half a period after the rising edge. Flags and selection for a branch are changed only during its displacement cycle, so the previous branch's test cycle never sees them.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_OFS  = 2'd1,
    ST_TEST = 2'd2,
    ST_FIX  = 2'd3
  } rbs_state_e;

  typedef enum logic [1:0] {
    FLG_N = 2'd0,
    FLG_V = 2'd1,
    FLG_Z = 2'd2,
    FLG_C = 2'd3
  } rbs_flag_e;

  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CYC_SEQ   = 3'd2;
  localparam logic [CNT_W-1:0] CYC_SAME  = 3'd3;
  localparam logic [CNT_W-1:0] CYC_CROSS = 3'd4;

endpackage

// File: rtl/rbs_cond_unit.sv
module rbs_cond_unit
  import rbs_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       flag_n,
  input  logic       flag_v,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       take
);

  function automatic logic pick_flag(input rbs_flag_e idx, input logic n, input logic v,
                                     input logic z, input logic c);
    case (idx)
      FLG_N:   return n;
      FLG_V:   return v;
      FLG_Z:   return z;
      default: return c;
    endcase
  endfunction

  logic chosen;
  assign chosen = pick_flag(rbs_flag_e'(sel[2:1]), flag_n, flag_v, flag_z, flag_c);
  assign take   = (chosen == sel[0]);

endmodule

// File: rtl/rbs_low_adder.sv
module rbs_low_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] low_in,
  input  logic [DATA_W-1:0] disp,
  output logic [DATA_W-1:0] low_sum,
  output logic              page_cross,
  output logic              step_down
);

  function automatic logic [DATA_W:0] add_low(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [DATA_W:0] full;
  assign full      = add_low(low_in, disp);
  assign low_sum   = full[DATA_W-1:0];
  // Positive displacement with carry out, or negative without carry (borrow).
  assign page_cross = full[DATA_W] ^ disp[DATA_W-1];
  assign step_down  = disp[DATA_W-1];

endmodule

// File: rtl/rbs_high_fix.sv
module rbs_high_fix #(
  parameter int HI_W = 8
) (
  input  logic [HI_W-1:0] high_in,
  input  logic            step_down,
  output logic [HI_W-1:0] high_out
);

  function automatic logic [HI_W-1:0] step_page(input logic [HI_W-1:0] h, input logic dn);
    return dn ? (h - HI_W'(1)) : (h + HI_W'(1));
  endfunction

  assign high_out = step_page(high_in, step_down);

endmodule

// File: rtl/rel_branch_seq.sv
module rel_branch_seq
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [2:0]        cond_sel,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  output logic              op_fetch,
  output logic              br_done,
  output logic [CNT_W-1:0]  br_cycles
);

  localparam int HI_W = ADDR_W - DATA_W;

  rbs_state_e        st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] disp_q;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  pend_cnt_q, pend_cnt_d;

  logic [DATA_W-1:0] pcl;
  logic [HI_W-1:0]   pch;
  logic [DATA_W-1:0] sum_lo;
  logic [HI_W-1:0]   pch_step;
  logic              take_raw, cross_w, down_w;

  // Named internal events for the checker.
  logic test_w, take_w, fix_w;

  assign pcl = pc_q[DATA_W-1:0];
  assign pch = pc_q[ADDR_W-1:DATA_W];

  rbs_cond_unit u_cond (
    .sel    (cond_sel),
    .flag_n (flag_n),
    .flag_v (flag_v),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .take   (take_raw)
  );

  rbs_low_adder #(.DATA_W(DATA_W)) u_add (
    .low_in     (pcl),
    .disp       (disp_q),
    .low_sum    (sum_lo),
    .page_cross (cross_w),
    .step_down  (down_w)
  );

  rbs_high_fix #(.HI_W(HI_W)) u_fix (
    .high_in   (pch),
    .step_down (down_w),
    .high_out  (pch_step)
  );

  assign test_w = (st_q == ST_TEST);
  assign take_w = test_w & take_raw;
  assign fix_w  = (st_q == ST_FIX);

  always_comb begin
    st_d       = st_q;
    pc_d       = pc_q;
    pend_d     = 1'b0;
    pend_cnt_d = pend_cnt_q;
    case (st_q)
      ST_OPC: begin
        pc_d = pc_q + ADDR_W'(1);
        st_d = ST_OFS;
      end
      ST_OFS: begin
        pc_d = pc_q + ADDR_W'(1);
        st_d = ST_TEST;
      end
      ST_TEST: begin
        if (!take_raw) begin
          // This cycle already fetched the next opcode.
          pc_d = pc_q + ADDR_W'(1);
          st_d = ST_OFS;
        end else begin
          pc_d = {pch, sum_lo};
          if (cross_w) begin
            st_d = ST_FIX;
          end else begin
            st_d       = ST_OPC;
            pend_d     = 1'b1;
            pend_cnt_d = CYC_SAME;
          end
        end
      end
      default: begin
        pc_d       = {pch_step, pcl};
        st_d       = ST_OPC;
        pend_d     = 1'b1;
        pend_cnt_d = CYC_CROSS;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_OPC;
      pc_q       <= RESET_PC;
      disp_q     <= '0;
      pend_q     <= 1'b0;
      pend_cnt_q <= '0;
    end else begin
      st_q       <= st_d;
      pc_q       <= pc_d;
      pend_q     <= pend_d;
      pend_cnt_q <= pend_cnt_d;
      if (st_q == ST_OFS) disp_q <= mem_rdata;
    end
  end

  logic seq_done;
  logic jump_done;
  assign seq_done  = test_w & ~take_raw;
  assign jump_done = (st_q == ST_OPC) & pend_q;

  assign mem_addr  = pc_q;
  assign op_fetch  = (st_q == ST_OPC) | seq_done;
  assign br_done   = seq_done | jump_done;
  assign br_cycles = seq_done ? CYC_SEQ : (jump_done ? pend_cnt_q : '0);

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              op_fetch,
  input logic              br_done,
  input logic [2:0]        br_cycles,
  input logic              test_w,
  input logic              take_w,
  input logic              fix_w
);

  localparam int HI_W = ADDR_W - DATA_W;

  // R2: an opcode cycle is followed by the displacement read at the next address.
  p_offset_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_fetch |=> (!op_fetch && mem_addr == ADDR_W'($past(mem_addr) + 1)));

  // R4: an untaken test cycle is itself the next opcode fetch and reports 2.
  p_untaken_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_w && !take_w) |-> (op_fetch && br_done && br_cycles == 3'd2));

  // R6: the byte read in a taken test cycle is not an opcode.
  p_taken_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (!op_fetch && !br_done));

  // R7: after the dummy read the low byte holds and the page moves by one.
  p_fix_low_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_w |=> (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) &&
               op_fetch && br_done && br_cycles == 3'd4));

  p_fix_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fix_w |=> (mem_addr[ADDR_W-1:DATA_W] == HI_W'($past(mem_addr[ADDR_W-1:DATA_W]) + 1) ||
               mem_addr[ADDR_W-1:DATA_W] == HI_W'($past(mem_addr[ADDR_W-1:DATA_W]) - 1)));

  // R8: the completion pulse rides on an opcode fetch with a legal count, for one cycle.
  p_done_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |-> (op_fetch && br_cycles >= 3'd2 && br_cycles <= 3'd4));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_done |=> !br_done);

endmodule

bind rel_branch_seq rbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .op_fetch  (op_fetch),
  .br_done   (br_done),
  .br_cycles (br_cycles),
  .test_w    (test_w),
  .take_w    (take_w),
  .fix_w     (fix_w)
);

// File: tb/rel_branch_seq_test.sv
module rel_branch_seq_test;

  localparam int NB = 64;
  localparam logic [15:0] START_PC = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [2:0]  cond_sel = 3'd0;
  logic        flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
  logic        op_fetch, br_done;
  logic [2:0]  br_cycles;

  always #4 clk = ~clk;

  rel_branch_seq #(.ADDR_W(16), .DATA_W(8), .RESET_PC(START_PC)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cond_sel(cond_sel), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c), .op_fetch(op_fetch), .br_done(br_done), .br_cycles(br_cycles)
  );

  typedef struct {
    logic [15:0] addr;
    logic        opf;
    logic        done;
    logic [2:0]  cnt;
    int          apply;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [7:0]  disp_mem [int];
  logic [2:0]  sel_a [NB];
  logic [3:0]  flg_a [NB];   // [0]=N [1]=V [2]=Z [3]=C
  logic [7:0]  off_a [NB];
  int          n_cmp = 0, n_bad = 0;
  bit          finished = 0;
  int          k = 0;
  logic [15:0] next_pc = START_PC;
  int          pend = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic apply_cfg(int j);
    cond_sel = sel_a[j];
    {flag_c, flag_z, flag_v, flag_n} = flg_a[j];
  endtask

  function automatic bit is_taken(int j);
    return flg_a[j][sel_a[j][2:1]] == sel_a[j][0];
  endfunction

  task automatic gen(int j);
    exp_t e;
    logic [15:0] p, base, tgt;
    string t0;
    p    = next_pc;
    base = p + 16'd2;
    tgt  = base + {{8{off_a[j][7]}}, off_a[j]};   // R5 target arithmetic
    disp_mem[int'(p + 16'd1)] = off_a[j];
    t0 = (pend == 2) ? "R4" : (pend == 3) ? "R5+R6" : (pend == 4) ? "R5+R7" : "R8";
    e = '{addr: p, opf: 1'b1, done: (pend != 0), cnt: 3'(pend), apply: -1, tag: t0};
    q.push_back(e);
    e = '{addr: p + 16'd1, opf: 1'b0, done: 1'b0, cnt: 3'd0, apply: j, tag: "R2"};
    q.push_back(e);
    if (!is_taken(j)) begin
      next_pc = base;
      pend = 2;
    end else begin
      e = '{addr: base, opf: 1'b0, done: 1'b0, cnt: 3'd0, apply: -1, tag: "R3+R6"};
      q.push_back(e);
      if (tgt[15:8] == base[15:8]) pend = 3;
      else begin
        e = '{addr: {base[15:8], tgt[7:0]}, opf: 1'b0, done: 1'b0, cnt: 3'd0,
              apply: -1, tag: "R7"};
        q.push_back(e);
        pend = 4;
      end
      next_pc = tgt;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    for (int j = 0; j < NB; j++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel_a[j] = {2'(j % 4), 1'((j / 4) % 2)};
      flg_a[j] = lf[3:0];
      off_a[j] = lf[15:8];
    end
    // Directed cases: worked page-crossing example, zero, extreme displacements, untaken.
    off_a[0] = 8'hB0; sel_a[0] = 3'b111; flg_a[0] = 4'b1000;   // R7 worked case, carry set wanted 1
    off_a[1] = 8'h00; sel_a[1] = 3'b100; flg_a[1] = 4'b0000;   // zero flag wanted 0: taken
    off_a[2] = 8'h7F; sel_a[2] = 3'b001; flg_a[2] = 4'b0001;   // negative wanted 1: taken
    off_a[3] = 8'h80; sel_a[3] = 3'b010; flg_a[3] = 4'b0000;   // overflow wanted 0: taken
    off_a[4] = 8'h40; sel_a[4] = 3'b110; flg_a[4] = 4'b0000;   // carry wanted 0 but set below: untaken
    flg_a[4] = 4'b1000;
    off_a[5] = 8'h10; sel_a[5] = 3'b101; flg_a[5] = 4'b0000;   // zero wanted 1: untaken

    apply_cfg(0);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "reset addr", int'(mem_addr), int'(START_PC));
      chk("R1", "reset op_fetch", int'(op_fetch), 1);
      chk("R1", "reset done", int'(br_done), 0);
    end
    rst_n = 1'b1;
    forever begin
      exp_t e;
      if (q.size() == 0) begin
        if (k == NB) break;
        gen(k);
        k++;
      end
      e = q.pop_front();
      chk(e.tag, "addr", int'(mem_addr), int'(e.addr));
      chk(e.tag, "op_fetch", int'(op_fetch), int'(e.opf));
      chk(e.tag, "br_done", int'(br_done), int'(e.done));
      if (e.done) chk(e.tag, "br_cycles", int'(br_cycles), int'(e.cnt));
      mem_rdata = disp_mem.exists(int'(mem_addr)) ? disp_mem[int'(mem_addr)]
                                                  : (mem_addr[7:0] ^ 8'hA5);
      if (e.apply >= 0) apply_cfg(e.apply);
      @(negedge clk);
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule